// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM. It has a 36-bit common data bus, split here into an input, an output and a drive-enable. Every control input is sampled on a rising clock edge, and only when the active-low clock enable is low. A read is flow-through: the word at the address registered on an edge appears on the output during the cycle that follows that edge. A write takes its address and byte selects on one edge and takes its data from the bus on the next enabled edge. Because of this, reads and writes can follow each other in any order and no idle cycle is ever needed for bus turnaround.

An access starts on a load edge, when advance/load is low and the three chip enables are in their active states. Write enable picks the type of access. On later edges with advance/load high, a 2-bit burst offset steps forward. The type of access and the base address stay fixed for the whole burst. The mode input chooses between linear and interleaved ordering. The output drivers turn off in several cases whatever the asynchronous output enable says: while the device is deselected, during the data cycle of a write, and during the first cycle after leaving the deselected state.

Top module: `zt_sram`

## Requirements
- R1: While `clk_en_n` is high at an edge, no state changes and no memory word is written. The outputs stay as they were as long as `oe_n` and `burst_ilv` do not change.
- R2: An access loads on an edge where `clk_en_n`=0, `adv_ld`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A value of `we_n`=1 gives a read and `we_n`=0 gives a write.
- R3: The data of a write is taken from `d_in` on the next enabled edge after its command. A new command can be issued on that same edge, so back-to-back mixes of reads and writes need no idle cycle.
- R4: `bsel_n[k]` is active low and gates lane k. Lane k is `d_in[8k+7:8k]` together with parity bit `d_in[32+k]`. Lanes that are not selected keep their old contents.
- R5: A read drives the addressed word on `d_out` with `d_oe`=1 in the cycle after its edge. This happens only while `oe_n`=0. Raising `oe_n` drops `d_oe` at once, without waiting for a clock.
- R6: `d_oe` is 0 in the cycle that follows the edge of a write command or write burst beat.
- R7: A load edge with any chip enable inactive deselects the device. `d_oe` stays 0 while the device is deselected.
- R8: In the first cycle of an access loaded from the deselected state, `d_oe` is 0.
- R9: An enabled edge with `adv_ld`=1 steps the 2-bit burst offset of the active access. In linear order (`burst_ilv`=0) the low address bits are base+offset mod 4. In interleaved order (`burst_ilv`=1) they are base XOR offset. The upper address bits, the access type and the ignored `ce*`/`we_n` stay unchanged. `bsel_n` is sampled on every write beat.
- R10: An enabled edge with `adv_ld`=1 while the device is deselected leaves it deselected and writes nothing.
- R11: A read issued right after a write to the same address returns the newly written lanes merged with the lanes that were not selected.
- R12: Reset deselects the device with `d_oe`=0 and drops any write whose data has not yet been taken. Memory contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; when high, the cycle is extended |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; sampled on load edges only |
| adv_ld | input | 1 | High: advance the burst; low: load a new access |
| bsel_n | input | 4 | Active-low byte lane selects for writes |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW (6) | Word address |
| d_in | input | 36 | Bus input: data in bits 31:0, parity in bits 35:32 |
| d_out | output | 36 | Bus output, zero while not driving |
| d_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume `rst_n` changes only away from the rising edge. They also assume that `burst_ilv` is held steady while a burst is in progress, and that the output-hold property is only required across cycles in which `oe_n` stays still. The stimulus therefore changes every input at the falling edge, including reset release, and it changes the burst order only between bursts. The reference model writes every address before any data comparison is made, so no comparison ever depends on uninitialised memory.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    localparam int LANES       = 4;
    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;
    localparam int DATA_W      = LANES * LANE_DATA_W;
    localparam int WORD_W      = LANES * LANE_W;
    localparam int BURST_W     = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/zt_burst_addr.sv
module zt_burst_addr
    import zt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0]      base,
    input  logic [BURST_W-1:0] ofs,
    input  burst_order_e       order,
    output logic [AW-1:0]      addr
);
    logic [BURST_W-1:0] low;

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: low = base[BURST_W-1:0] ^ ofs;
            default:        low = base[BURST_W-1:0] + ofs;
        endcase
        addr = {base[AW-1:BURST_W], low};
    end
endmodule

// File: rtl/zt_sram_ctl.sv
module zt_sram_ctl
    import zt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             we_n,
    input  logic             adv_ld,
    input  logic [LANES-1:0] bsel_n,
    input  logic             burst_ilv,
    input  logic [AW-1:0]    addr,
    output logic             act,
    output logic             is_wr,
    output logic             fresh,
    output logic [AW-1:0]    cur_addr,
    output logic             wr_commit,
    output logic [LANES-1:0] wr_bsel_n
);
    typedef struct packed {
        logic               act;
        logic               wr;
        logic               fresh;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] ofs;
        logic [LANES-1:0]   bsel_n;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    en;
    logic    chip_sel;

    zt_burst_addr #(.AW(AW)) u_cur_addr (
        .base  (st_q.base),
        .ofs   (st_q.ofs),
        .order (burst_order_e'(burst_ilv)),
        .addr  (cur_addr)
    );

    always_comb begin
        en        = !clk_en_n;
        chip_sel  = !ce1_n && ce2 && !ce3_n;
        st_d      = st_q;
        // The write of the current beat takes its data on this edge.
        wr_commit = en && st_q.act && st_q.wr;
        if (en) begin
            st_d.fresh = 1'b0;
            if (!adv_ld) begin
                if (chip_sel) begin
                    st_d.act   = 1'b1;
                    st_d.wr    = !we_n;
                    st_d.base  = addr;
                    st_d.ofs   = '0;
                    st_d.fresh = !st_q.act;
                end else begin
                    st_d.act = 1'b0;
                end
            end else if (st_q.act) begin
                st_d.ofs = st_q.ofs + 1'b1;
            end
            if (st_d.act && st_d.wr) begin
                st_d.bsel_n = bsel_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act       = st_q.act;
    assign is_wr     = st_q.wr;
    assign fresh     = st_q.fresh;
    assign wr_bsel_n = st_q.bsel_n;
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array
    import zt_sram_pkg::*;
#(
    parameter int AW    = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] wlane;
        logic [LANE_W-1:0] rlane;

        assign wlane = {wdata[DATA_W + k], wdata[k*LANE_DATA_W +: LANE_DATA_W]};

        always_ff @(posedge clk) begin
            if (we && !lane_n[k]) begin
                mem[addr] <= wlane;
            end
        end

        assign rlane = mem[addr];
        assign rdata[k*LANE_DATA_W +: LANE_DATA_W] = rlane[LANE_DATA_W-1:0];
        assign rdata[DATA_W + k]                   = rlane[LANE_DATA_W];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              burst_ilv,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] d_in,
    output logic [WORD_W-1:0] d_out,
    output logic              d_oe
);
    logic              ctl_act;
    logic              ctl_wr;
    logic              ctl_fresh;
    logic [AW-1:0]     ctl_addr;
    logic              ctl_commit;
    logic [LANES-1:0]  ctl_bsel_n;
    logic [WORD_W-1:0] rd_word;

    zt_sram_ctl #(.AW(AW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .we_n      (we_n),
        .adv_ld    (adv_ld),
        .bsel_n    (bsel_n),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .act       (ctl_act),
        .is_wr     (ctl_wr),
        .fresh     (ctl_fresh),
        .cur_addr  (ctl_addr),
        .wr_commit (ctl_commit),
        .wr_bsel_n (ctl_bsel_n)
    );

    zt_sram_array #(.AW(AW)) u_array (
        .clk    (clk),
        .we     (ctl_commit),
        .lane_n (ctl_bsel_n),
        .addr   (ctl_addr),
        .wdata  (d_in),
        .rdata  (rd_word)
    );

    always_comb begin
        d_oe  = ctl_act && !ctl_wr && !ctl_fresh && !oe_n;
        d_out = d_oe ? rd_word : '0;
    end
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en_n,
    input logic        ce1_n,
    input logic        ce2,
    input logic        ce3_n,
    input logic        we_n,
    input logic        adv_ld,
    input logic        burst_ilv,
    input logic        oe_n,
    input logic [35:0] d_out,
    input logic        d_oe,
    input logic        act
);
    a_r1_hold_on_clk_en: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clk_en_n) && $stable(oe_n) && $stable(burst_ilv) |-> $stable(d_oe) && $stable(d_out));

    a_r5_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !d_oe);

    a_r6_write_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !adv_ld && !ce1_n && ce2 && !ce3_n && !we_n) |-> !d_oe);

    a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |-> !d_oe && !act);

    a_r8_emerge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> !d_oe);

    a_r10_stay_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!act && !clk_en_n && adv_ld) |-> !act);
endmodule

bind zt_sram zt_sram_chk u_zt_sram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .we_n      (we_n),
    .adv_ld    (adv_ld),
    .burst_ilv (burst_ilv),
    .oe_n      (oe_n),
    .d_out     (d_out),
    .d_oe      (d_oe),
    .act       (ctl_act)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic        we_n = 1'b1, adv_ld = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [3:0]  bsel_n = 4'h0;
    logic [5:0]  addr = '0;
    logic [35:0] d_in = '0;
    logic [35:0] d_out;
    logic        d_oe;

    int vecs = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [35:0] mm [int];
    bit m_act = 0, m_wr = 0, m_fresh = 0;
    int m_base = 0, m_ofs = 0;
    logic [3:0] m_bs = 4'hF;

    always #10 clk = ~clk;

    zt_sram i_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .bsel_n(bsel_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe)
    );

    function automatic int m_addr();
        int lo;
        if (burst_ilv) lo = (m_base & 3) ^ m_ofs;
        else           lo = ((m_base & 3) + m_ofs) & 3;
        return (m_base & ~3) | lo;
    endfunction

    task automatic model_edge();
        logic [35:0] w;
        int a;
        if (!rst_n) begin
            m_act = 0; m_fresh = 0; m_wr = 0;
            return;
        end
        if (clk_en_n) return;
        if (m_act && m_wr) begin
            a = m_addr();
            w = mm.exists(a) ? mm[a] : 36'h0;
            for (int k = 0; k < 4; k++)
                if (!m_bs[k]) begin
                    w[8*k +: 8] = d_in[8*k +: 8];
                    w[32+k]     = d_in[32+k];
                end
            mm[a] = w;
        end
        m_fresh = 0;
        if (!adv_ld) begin
            if (!ce1_n && ce2 && !ce3_n) begin
                m_fresh = !m_act;
                m_act = 1; m_wr = !we_n; m_base = addr; m_ofs = 0;
            end else m_act = 0;
        end else if (m_act) m_ofs = (m_ofs + 1) & 3;
        if (m_act && m_wr) m_bs = bsel_n;
    endtask

    task automatic check(input string tag);
        bit exp_oe;
        int a;
        exp_oe = m_act && !m_wr && !m_fresh && !oe_n;
        a = m_addr();
        vecs++;
        if (d_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s d_oe actual=%0b expected=%0b at %0t", tag, d_oe, exp_oe, $time);
        end else if (exp_oe && mm.exists(a) && d_out !== mm[a]) begin
            fails++;
            $display("FAIL %s d_out actual=%h expected=%h addr=%0d", tag, d_out, mm[a], a);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #5;
        check(tag);
        @(negedge clk);
        d_in = 36'h9_1357_2468 ^ (36'(vecs) * 36'h0_0F1D_3B5) ^ {vecs[3:0], 32'h0};
    endtask

    task automatic op(input bit cen, input bit c1, input bit c2, input bit c3,
                      input bit we, input bit adv, input logic [3:0] bs,
                      input int a, input string tag);
        clk_en_n = cen; ce1_n = c1; ce2 = c2; ce3_n = c3;
        we_n = we; adv_ld = adv; bsel_n = bs; addr = 6'(a);
        step(tag);
    endtask

    task automatic rd(input int a, input string tag);
        op(0, 0, 1, 0, 1, 0, 4'h0, a, tag);
    endtask
    task automatic wr(input int a, input logic [3:0] bs, input string tag);
        op(0, 0, 1, 0, 0, 0, bs, a, tag);
    endtask
    // chip enables off and we_n toggled: both must be ignored on a burst step
    task automatic adv(input logic [3:0] bs, input string tag);
        op(0, 1, 0, 1, 0, 1, bs, 63, tag);
    endtask
    task automatic desel(input string tag);
        op(0, 1, 1, 0, 1, 0, 4'h0, 0, tag);
    endtask
    task automatic hold(input string tag);
        op(1, 0, 1, 0, 0, 0, 4'h0, 17, tag);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state, drivers off even with oe_n low
        vecs++;
        if (d_oe !== 1'b0) begin fails++; $display("FAIL R12 reset d_oe actual=%0b expected=0", d_oe); end
        rst_n = 1'b1;
        desel("R12");

        // R2 R3: back-to-back full-word writes fill the array
        for (int i = 0; i < 64; i++) wr(i, 4'h0, "R3");
        desel("R7");
        rd(0, "R8");                           // first cycle after deselect hidden
        for (int i = 0; i < 64; i++) rd(i, "R2");

        // R4 R11: byte lanes and read right after write
        wr(10, 4'b0101, "R4");
        rd(10, "R11");
        wr(11, 4'b1010, "R4");
        wr(12, 4'b0000, "R3");
        rd(11, "R11");
        rd(12, "R3");
        wr(13, 4'b1111, "R4");
        rd(13, "R4");

        // R5: output enable gating, registered and asynchronous
        oe_n = 1'b1; rd(14, "R5");
        oe_n = 1'b0; rd(14, "R5");
        oe_n = 1'b1; #1;
        vecs++;
        if (d_oe !== 1'b0) begin fails++; $display("FAIL R5 async off actual=%0b expected=0", d_oe); end
        oe_n = 1'b0; #1;
        vecs++;
        if (d_oe !== 1'b1 || d_out !== mm[14]) begin
            fails++; $display("FAIL R5 async on actual=%0b/%h expected=1/%h", d_oe, d_out, mm[14]);
        end

        // R9: bursts in both orders, read and write
        burst_ilv = 1'b0;
        rd(6, "R9"); adv(4'h0, "R9"); adv(4'h0, "R9"); adv(4'h0, "R9"); adv(4'h0, "R9");
        rd(9, "R9"); adv(4'h0, "R9");
        burst_ilv = 1'b1;
        rd(7, "R9"); adv(4'h0, "R9"); adv(4'h0, "R9"); adv(4'h0, "R9");
        wr(21, 4'b1110, "R6"); adv(4'b0000, "R6"); adv(4'b0111, "R9"); adv(4'b1111, "R9");
        rd(20, "R9"); rd(21, "R9"); rd(22, "R9"); rd(23, "R9");
        burst_ilv = 1'b0;
        wr(26, 4'b0000, "R6"); adv(4'b1100, "R9"); adv(4'b0011, "R9");
        rd(24, "R9"); rd(25, "R9"); rd(26, "R9"); rd(27, "R9");

        // R1: clock enable high extends cycles, including a pending write
        rd(30, "R1"); hold("R1"); hold("R1"); adv(4'h0, "R1");
        wr(31, 4'b0000, "R1"); hold("R1"); hold("R1"); hold("R1");
        rd(31, "R1"); rd(30, "R1");

        // R7 R8 R10: deselect through each enable, advance while deselected
        op(0, 1, 1, 0, 1, 0, 4'h0, 3, "R7"); rd(3, "R8"); rd(3, "R7");
        op(0, 0, 0, 0, 1, 0, 4'h0, 3, "R7"); rd(4, "R8"); rd(4, "R7");
        op(0, 0, 1, 1, 0, 0, 4'h0, 3, "R7");
        op(0, 0, 1, 0, 0, 1, 4'h0, 40, "R10");   // would-be write, still deselected
        op(0, 0, 1, 0, 1, 1, 4'h0, 41, "R10");
        rd(40, "R8"); rd(40, "R10"); rd(41, "R10");

        // R12: reset drops a write whose data phase has not happened
        wr(5, 4'b0000, "R12");
        rst_n = 1'b0;
        step("R12");
        rst_n = 1'b1;
        desel("R12");
        rd(5, "R12"); rd(5, "R12");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule